// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 12-bit DAC. A host talks to it over a framed serial link with four signals: an active-low frame select, a serial clock, data in and data out. Each frame carries 16 bits. The frame takes effect on the falling serial-clock edge that ends its sixteenth bit. A frame that is cut short has no effect.

Every channel has two registers: an input register that the serial link writes, and a DAC register that drives the channel's output value. A per-channel new-data flag records a write that has not yet moved to the DAC register. The load strobe is active low. While it is low, every flagged channel copies its input register to its DAC register, so the outputs change together. A short low pulse updates all flagged channels at once. Holding the strobe low makes the DAC registers follow each completed write. The falling edge of the clear input zeroes all channel registers. While clear stays low, the load strobe has no effect.

All inputs are sampled on a block clock `clk` that runs much faster than the serial clock. Each input passes through two flops before use.

Top module: `quad_dac_serial_if`

## Requirements
- R1: `alarm_n` is low exactly when `overtemp` is high.
- R2: A frame is 16 bits, sent MSB first. Bit 15 is the read flag (1 = read, 0 = write), bits 14:12 are the address and bits 11:0 are the data. A write to address 1, 2, 3 or 4 loads the data into the input register of channel A, B, C or D. The load happens on the 16th falling serial-clock edge while the frame select is low. A write to address 0, 5 or 6 changes nothing.
- R3: If the frame select goes high before the 16th falling edge, the frame changes no register.
- R4: Serial-clock edges while the frame select is high are ignored. Bits after the 16th in the same frame are also ignored.
- R5: While the load strobe is high, a write does not change any DAC register. When the strobe goes low, every channel whose new-data flag is set copies its input register to its DAC register, and its flag is cleared. Channels without the flag keep their DAC value.
- R6: With the load strobe held low, each DAC register takes the value written to its channel shortly after the frame completes.
- R7: A falling edge on `clr_n` sets every input register and every DAC register to 0x000, and clears every new-data flag.
- R8: While `clr_n` is low, the load strobe is ignored, but writes still land in the input registers. After `clr_n` returns high, those writes are transferred normally.
- R9: A read frame to address A loads a 16-bit word into the output shift register. For a channel address the word is `{4'b0, input register}`. For address 7 it is `{4'b0, control register}`. For any other address it is zero. The word is shifted out MSB first during the next frame.
- R10: `sdo` changes only after a rising serial-clock edge. The first bit of a frame is on `sdo` before the first rising edge, and each bit stays valid until the next rising edge.
- R11: After `rst_n`, all registers and `sdo` are zero.
- R12: A write to address 7 stores its data in the control register. Clear leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear, acts on its falling edge |
| overtemp | input | 1 | Over-temperature flag |
| sdo | output | 1 | Serial readback data, launched on rising sclk |
| alarm_n | output | 1 | Active-low over-temperature alarm |
| dac_a | output | 12 | DAC register, channel A |
| dac_b | output | 12 | DAC register, channel B |
| dac_c | output | 12 | DAC register, channel C |
| dac_d | output | 12 | DAC register, channel D |

## Verification
The hardest case to reach is a write that arrives while clear is held low. That write must stay pending across the clear and reach the DAC register only after clear is released. To get there, the stimulus holds the load strobe low, then drops clear, then writes a channel. It reads the input register back through the serial port and checks the DAC output still reads zero. It then raises clear and checks that the DAC output catches up. Two other cases need precise timing at the ports. For the aborted frame, the frame select is raised during the high phase of the 16th clock. For the over-long frame, four extra clocks of ones are sent after the 16th bit.

// File: rtl/quad_dac_serial_if.sv
module quad_dac_serial_if #(
  parameter int DW        = 12,
  parameter int AW        = 3,
  parameter int CTRL_ADDR = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          ldac_n,
  input  logic          clr_n,
  input  logic          overtemp,
  output logic          sdo,
  output logic          alarm_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic [DW-1:0] dac_c,
  output logic [DW-1:0] dac_d
);
  localparam int NCH = 4;
  localparam int FW  = 1 + AW + DW;
  localparam int CW  = $clog2(FW + 1);
  localparam logic [CW-1:0] FULL = CW'(FW);
  localparam logic [4:0] IDLE = 5'b10011;

  // two-flop sampling of {sync_n, sclk, sdi, ldac_n, clr_n}
  logic [4:0] m1, m2;
  logic       sck_q, clr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= IDLE; m2 <= IDLE; sck_q <= 1'b0; clr_q <= 1'b1;
    end else begin
      m1 <= {sync_n, sclk, sdi, ldac_n, clr_n};
      m2 <= m1; sck_q <= m2[3]; clr_q <= m2[0];
    end

  logic fs_n, sck_rise, sck_fall, ld_lo, clr_lo, clr_fall;
  assign fs_n     = m2[4];
  assign sck_rise = m2[3] & ~sck_q;
  assign sck_fall = ~m2[3] & sck_q;
  assign ld_lo    = ~m2[1];
  assign clr_lo   = ~m2[0];
  assign clr_fall = ~m2[0] & clr_q;

  logic [FW-1:0] shreg, out_sr;
  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0; cnt <= '0; done <= 1'b0;
    end else if (fs_n) begin
      cnt <= '0; done <= 1'b0;
    end else begin
      if (sck_rise && cnt < FULL) begin
        shreg <= {shreg[FW-2:0], m2[2]};
        cnt   <= cnt + 1'b1;
      end
      if (sck_fall && cnt == FULL) done <= 1'b1;
    end

  logic          commit, rw;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  assign commit = sck_fall && !fs_n && cnt == FULL && !done;
  assign rw     = shreg[FW-1];
  assign addr   = shreg[FW-2 -: AW];
  assign wdata  = shreg[DW-1:0];

  logic [NCH-1:0][DW-1:0] in_r, dac_r;
  logic [NCH-1:0]         nf, wr_hit;
  logic [DW-1:0]          ctrl_r, rb_val;

  always_comb begin
    rb_val = '0;
    for (int i = 0; i < NCH; i++) begin
      wr_hit[i] = commit && !rw && addr == AW'(i + 1);
      if (addr == AW'(i + 1)) rb_val = in_r[i];
    end
    if (addr == AW'(CTRL_ADDR)) rb_val = ctrl_r;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_r <= '0; dac_r <= '0; nf <= '0;
    end else if (clr_fall) begin
      in_r <= '0; dac_r <= '0; nf <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_hit[i]) begin
          in_r[i] <= wdata;
          nf[i]   <= 1'b1;
        end else if (ld_lo && !clr_lo && nf[i]) begin
          dac_r[i] <= in_r[i];
          nf[i]    <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_r <= '0;
    else if (commit && !rw && addr == AW'(CTRL_ADDR)) ctrl_r <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_sr <= '0;
    else if (commit && rw) out_sr <= {{(FW-DW){1'b0}}, rb_val};
    else if (sck_rise && !fs_n && cnt != '0) out_sr <= {out_sr[FW-2:0], 1'b0};

  assign sdo     = out_sr[FW-1];
  assign alarm_n = ~overtemp;
  assign dac_a   = dac_r[0];
  assign dac_b   = dac_r[1];
  assign dac_c   = dac_r[2];
  assign dac_d   = dac_r[3];

  a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    fs_n && !clr_fall |=> $stable(in_r));
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lo && !clr_fall |=> $stable(dac_r));
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (in_r == '0 && dac_r == '0 && nf == '0));
  a_r8_clear_masks_load: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo && !clr_fall |=> $stable(dac_r));
  a_r10_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise && !(commit && rw) |=> $stable(sdo));
endmodule

// File: tb/sim_quad_dac_serial_if.sv
module sim_quad_dac_serial_if;
  localparam int CLK_P = 10;
  localparam int HP    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ldac_n = 1'b1, clr_n = 1'b1, overtemp = 1'b0;
  logic sdo, alarm_n;
  logic [11:0] dac_a, dac_b, dac_c, dac_d;
  int n_run = 0, n_fail = 0;
  logic [15:0] ch, cl, rv;

  quad_dac_serial_if u0 (.clk, .rst_n, .sync_n, .sclk, .sdi, .ldac_n, .clr_n, .overtemp,
                         .sdo, .alarm_n, .dac_a, .dac_b, .dac_c, .dac_d);

  always #(CLK_P/2) clk = ~clk;

  // {word[15:0], channel to check[1:0], expected DAC value[11:0]}, load strobe held low
  localparam logic [29:0] VEC [8] = '{
    {16'h1ABC, 2'd0, 12'hABC}, {16'h2123, 2'd1, 12'h123},
    {16'h3FFF, 2'd2, 12'hFFF}, {16'h4001, 2'd3, 12'h001},
    {16'h0555, 2'd0, 12'hABC}, {16'h5777, 2'd3, 12'h001},
    {16'h1000, 2'd0, 12'h000}, {16'h6FFF, 2'd1, 12'h123}};

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] dac_of(input int c);
    case (c)
      0: return dac_a;
      1: return dac_b;
      2: return dac_c;
      default: return dac_d;
    endcase
  endfunction

  task automatic frame(input logic [15:0] w, input int nrise, input bit abort,
                       output logic [15:0] cap_h, output logic [15:0] cap_l);
    cap_h = '0; cap_l = '0;
    sync_n = 1'b0;
    wait_clk(HP);
    for (int k = 0; k < nrise; k++) begin
      sdi = (k < 16) ? w[15-k] : 1'b1;
      wait_clk(HP);
      if (k >= 1 && k <= 15) cap_l[16-k] = sdo;
      sclk = 1'b1;
      wait_clk(HP);
      if (k < 16) cap_h[15-k] = sdo;
      if (abort && k == nrise - 1) begin
        sync_n = 1'b1;
        wait_clk(3);
      end
      sclk = 1'b0;
    end
    cap_l[0] = cap_h[0];
    wait_clk(HP);
    sync_n = 1'b1;
    wait_clk(4 * HP);
  endtask

  task automatic read_back(input logic [2:0] a, output logic [15:0] v);
    logic [15:0] h, l;
    frame({1'b1, a, 12'h000}, 16, 1'b0, h, l);
    frame(16'h0000, 16, 1'b0, v, l);
  endtask

  initial begin
    wait_clk(200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    check("R11 reset dac_a", {4'h0, dac_a}, 16'h0);
    check("R11 reset dac_d", {4'h0, dac_d}, 16'h0);
    check("R11 reset sdo", {15'h0, sdo}, 16'h0);
    check("R1 alarm idle", {15'h0, alarm_n}, 16'h1);
    overtemp = 1'b1; wait_clk(1);
    check("R1 alarm raised", {15'h0, alarm_n}, 16'h0);
    overtemp = 1'b0;

    // R2 R6: table walk with the load strobe held low
    ldac_n = 1'b0;
    foreach (VEC[i]) begin
      frame(VEC[i][29:14], 16, 1'b0, ch, cl);
      check("R2 R6 table write", {4'h0, dac_of(int'(VEC[i][13:12]))}, {4'h0, VEC[i][11:0]});
    end

    // R5: strobe high holds DAC, readback shows input register
    ldac_n = 1'b1; wait_clk(4);
    frame(16'h2456, 16, 1'b0, ch, cl);
    check("R5 held while strobe high", {4'h0, dac_b}, 16'h0123);
    read_back(3'd2, rv);
    check("R9 read channel B input", rv, 16'h0456);
    ldac_n = 1'b0; wait_clk(6); ldac_n = 1'b1; wait_clk(4);
    check("R5 pulse loads B", {4'h0, dac_b}, 16'h0456);
    check("R5 pulse leaves A", {4'h0, dac_a}, 16'h0000);

    // R10: bits held from rising edge to next rising edge
    frame(16'h7ABC, 16, 1'b0, ch, cl);
    frame(16'hF000, 16, 1'b0, ch, cl);
    frame(16'h0000, 16, 1'b0, ch, cl);
    check("R12 R9 read control", ch, 16'h0ABC);
    check("R10 bits stable until next rise", cl, 16'h0ABC);
    read_back(3'd5, rv);
    check("R9 unused address reads zero", rv, 16'h0000);

    // R3: aborted frames
    ldac_n = 1'b0;
    frame(16'h3AAA, 16, 1'b1, ch, cl);
    check("R3 abort at 16th bit", {4'h0, dac_c}, 16'h0FFF);
    frame(16'h3555, 15, 1'b0, ch, cl);
    check("R3 short frame", {4'h0, dac_c}, 16'h0FFF);
    read_back(3'd3, rv);
    check("R3 input C unchanged", rv, 16'h0FFF);

    // R4: clocks with frame select high, and extra bits
    for (int k = 0; k < 16; k++) begin
      sdi = k[0]; wait_clk(HP); sclk = 1'b1; wait_clk(HP); sclk = 1'b0;
    end
    wait_clk(4 * HP);
    check("R4 clocks while idle", {4'h0, dac_d}, 16'h0001);
    frame(16'h4222, 20, 1'b0, ch, cl);
    check("R4 extra bits ignored", {4'h0, dac_d}, 16'h0222);

    // R7 R8: clear with strobe held low
    clr_n = 1'b0; wait_clk(6);
    check("R7 clear zeroes A", {4'h0, dac_a}, 16'h0);
    check("R7 clear zeroes B", {4'h0, dac_b}, 16'h0);
    check("R7 clear zeroes D", {4'h0, dac_d}, 16'h0);
    read_back(3'd2, rv);
    check("R7 clear zeroes input B", rv, 16'h0000);
    frame(16'h1321, 16, 1'b0, ch, cl);
    check("R8 load masked during clear", {4'h0, dac_a}, 16'h0);
    read_back(3'd1, rv);
    check("R8 write lands during clear", rv, 16'h0321);
    clr_n = 1'b1; wait_clk(8);
    check("R8 transfer after clear", {4'h0, dac_a}, 16'h0321);
    read_back(3'd7, rv);
    check("R12 control survives clear", rv, 16'h0ABC);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule